// File: doc/BRIEF.md
# Grouped Match-Channel Timer Bank

This block holds eight match channels, numbered 4 to 11. Each channel has a 32-bit counter, a 32-bit match value and a control word. The control word picks one of five tick enables that arrive on `tick_in`. It also sets whether a match returns the counter to zero, whether the channel stays armed after it fires, and whether the channel runs on its own counter or compares against the counter of its group leader. The groups are 4–7 led by 4, 8–9 led by 8, and 10–11 led by 10. The tick generators are outside the block. Each `tick_in` bit is a one-cycle count enable in the `clk` domain.

Software reaches the block through a plain register bus: byte addresses, a write strobe and a read strobe. Read data is registered and is returned one cycle after the strobe, with `bus_rvalid` high. Reading the counter of channel 9 or 11 can copy the counter of channel 8 or 10 into a snapshot register. This lets a pair of counters be sampled together. A match event sets a status bit when its enable bit is set, and one interrupt line is the OR of all status bits.

Top module: `match_bank_timer`

## Requirements
- R1: After reset, every counter, match value, control word, the status bits, the enable bits and the snapshot read zero, and `irq` is low.
- R2: Control bits [2:0] pick the tick: code 1 uses `tick_in[0]`, 2 uses `tick_in[1]`, 3 uses `tick_in[2]`, 4 uses `tick_in[3]` and 5 uses `tick_in[4]`. Codes 0, 6 and 7 stop the channel, so its counter holds and it raises no event.
- R3: A write to a counter register loads the written value. When a load and a tick land in the same cycle, the loaded value is kept.
- R4: On a tick where the compared count equals the match value, a match occurs. The counter then takes zero if control bit 3 is set, or count+1 if it is clear. With bit 3 set and match value M, a channel fires every M+1 ticks.
- R5: With control bit 6 set, a channel fires on every match. With bit 6 clear it fires once and then ignores matches until its match or control register is written.
- R6: With control bit 7 clear, channels 5–7 compare channel 4's counter on channel 4's ticks, channel 9 follows channel 8, and channel 11 follows channel 10. A follower's own counter then holds its value. Channels 4, 8 and 10 count by their own selection whatever bit 7 holds. With bit 7 set, a channel counts by its own selection.
- R7: Control words of channels 4–7 keep bits [7:0] and read the rest as zero. Those of channels 8–11 keep bits [9:0], and bit 8 set stops the channel.
- R8: Reading the counter of channel 9 (0x54) or 11 (0x5C) while that channel's control bit 9 is set copies the counter of channel 8 or 10 into the snapshot register at 0x20. No other access changes the snapshot.
- R9: Status (0x14) and enable (0x1C) use bits [11:4], bit n for channel n. A match sets status bit n only if enable bit n is set. Writing 1 to a status bit clears it, and a new event in the same cycle keeps the bit set.
- R10: `irq` is high exactly while any status bit is set. It rises the cycle after the event that sets the first one.
- R11: Counters sit at 0x40+4·(n−4), match values at 0x80+4·(n−4) and control words at 0xC0+4·(n−4). `bus_rdata` and `bus_rvalid` update one cycle after `bus_rd`. Unmapped or misaligned reads return zero, and writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| tick_in | input | 5 | Tick enables for select codes 1 to 5 |
| irq | output | 1 | OR of all status bits |

## Verification
The checker assumes every `tick_in` pulse is a single-cycle enable synchronous to `clk`. It also assumes no channel can fire unless some tick input is high. The bench drives ticks, strobes and data only on falling edges and holds each one for exactly one cycle, so every event lines up with a single rising edge. The bench never applies a read and a write in the same cycle, because the snapshot check relies on the snapshot changing only under a read strobe.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  localparam int unsigned NUM_CH    = 8;
  localparam int unsigned IDX_W     = $clog2(NUM_CH);
  localparam int unsigned CTRL_W    = 10;
  localparam int unsigned WIDE_FROM = 4;   // local index of first 10-bit control
  localparam int unsigned STAT_LSB  = 4;   // status/enable bit of local channel 0

  localparam logic [7:0] OFS_STATUS = 8'h14;
  localparam logic [7:0] OFS_IEN    = 8'h1C;
  localparam logic [7:0] OFS_SNAP   = 8'h20;
  localparam logic [2:0] BANK_CNT   = 3'b010;
  localparam logic [2:0] BANK_MATCH = 3'b100;
  localparam logic [2:0] BANK_CTRL  = 3'b110;

  localparam int unsigned CB_ZERO  = 3;
  localparam int unsigned CB_REARM = 6;
  localparam int unsigned CB_OWN   = 7;
  localparam int unsigned CB_OFF   = 8;
  localparam int unsigned CB_SNAP  = 9;

  typedef enum logic [2:0] {
    RSEL_NONE, RSEL_CNT, RSEL_MATCH, RSEL_CTRL, RSEL_STATUS, RSEL_IEN, RSEL_SNAP
  } rsel_e;

  function automatic int unsigned leader_of(input int unsigned idx);
    if (idx < 4) return 0;
    else if (idx < 6) return 4;
    else return 6;
  endfunction
endpackage

// File: rtl/mbt_addr_decode.sv
module mbt_addr_decode
  import mbt_pkg::*;
#(
  parameter int unsigned CH = NUM_CH,
  parameter int unsigned IW = IDX_W
) (
  input  logic [7:0]    addr,
  input  logic          wr,
  output logic [CH-1:0] cnt_we,
  output logic [CH-1:0] match_we,
  output logic [CH-1:0] ctrl_we,
  output logic          ien_we,
  output logic          stat_we,
  output rsel_e         rsel,
  output logic [IW-1:0] ridx
);
  logic aligned, in_cnt, in_match, in_ctrl;

  assign aligned  = (addr[1:0] == 2'b00);
  assign in_cnt   = aligned && (addr[7:5] == BANK_CNT);
  assign in_match = aligned && (addr[7:5] == BANK_MATCH);
  assign in_ctrl  = aligned && (addr[7:5] == BANK_CTRL);
  assign ridx     = addr[2 +: IW];
  assign ien_we   = wr && (addr == OFS_IEN);
  assign stat_we  = wr && (addr == OFS_STATUS);

  for (genvar i = 0; i < CH; i++) begin : g_we
    assign cnt_we[i]   = wr && in_cnt   && (ridx == IW'(i));
    assign match_we[i] = wr && in_match && (ridx == IW'(i));
    assign ctrl_we[i]  = wr && in_ctrl  && (ridx == IW'(i));
  end

  always_comb begin
    if (in_cnt)                  rsel = RSEL_CNT;
    else if (in_match)           rsel = RSEL_MATCH;
    else if (in_ctrl)            rsel = RSEL_CTRL;
    else if (addr == OFS_STATUS) rsel = RSEL_STATUS;
    else if (addr == OFS_IEN)    rsel = RSEL_IEN;
    else if (addr == OFS_SNAP)   rsel = RSEL_SNAP;
    else                         rsel = RSEL_NONE;
  end
endmodule

// File: rtl/mbt_channel.sv
module mbt_channel
  import mbt_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_SRC = 5,
  parameter bit          WIDE    = 1'b0,
  parameter bit          LEADER  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic               match_we,
  input  logic               cnt_we,
  input  logic [CNT_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0] tick_in,
  input  logic [CNT_W-1:0]   lead_cnt,
  input  logic               lead_tick,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   match_q,
  output logic               own_tick,
  output logic               fire
);
  localparam logic [CTRL_W-1:0] KEEP = WIDE ? {CTRL_W{1'b1}} : CTRL_W'(8'hFF);

  logic             armed;
  logic             src_tick, uses_own, cmp_tick, hit;
  logic [CNT_W-1:0] cmp_cnt;

  always_comb begin
    src_tick = 1'b0;
    for (int k = 0; k < int'(NUM_SRC); k++)
      if (int'(ctrl_q[2:0]) == k + 1) src_tick = tick_in[k];
    if (WIDE && ctrl_q[CB_OFF]) src_tick = 1'b0;
  end

  assign uses_own = LEADER || ctrl_q[CB_OWN];
  assign own_tick = uses_own && src_tick;
  assign cmp_tick = uses_own ? own_tick : lead_tick;
  assign cmp_cnt  = uses_own ? cnt_q : lead_cnt;
  assign hit      = cmp_tick && (cmp_cnt == match_q);
  assign fire     = hit && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      match_q <= '0;
      cnt_q   <= '0;
      armed   <= 1'b1;
    end else begin
      if (ctrl_we)  ctrl_q  <= wdata[CTRL_W-1:0] & KEEP;
      if (match_we) match_q <= wdata;
      if (cnt_we)
        cnt_q <= wdata;
      else if (own_tick)
        cnt_q <= (hit && ctrl_q[CB_ZERO]) ? '0 : cnt_q + 1'b1;
      if (ctrl_we || match_we)
        armed <= 1'b1;
      else if (fire && !ctrl_q[CB_REARM])
        armed <= 1'b0;
    end
  end
endmodule

// File: rtl/mbt_status.sv
module mbt_status #(
  parameter int unsigned CH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ien_we,
  input  logic          stat_we,
  input  logic [CH-1:0] wbits,
  input  logic [CH-1:0] fire,
  output logic [CH-1:0] ien_q,
  output logic [CH-1:0] status_q,
  output logic          irq
);
  logic [CH-1:0] clr;

  assign clr = stat_we ? wbits : '0;
  assign irq = |status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q    <= '0;
      status_q <= '0;
    end else begin
      if (ien_we) ien_q <= wbits;
      status_q <= (status_q & ~clr) | (fire & ien_q);
    end
  end
endmodule

// File: rtl/match_bank_timer.sv
module match_bank_timer
  import mbt_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_addr,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_SRC-1:0] tick_in,
  output logic               irq
);
  logic [NUM_CH-1:0]             cnt_we, match_we, ctrl_we;
  logic                          ien_we, stat_we;
  rsel_e                         rsel;
  logic [IDX_W-1:0]              ridx;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_q, match_q;
  logic [NUM_CH-1:0]             own_tick, fire_v, rearm_v;
  logic [NUM_CH-1:0]             ien_q, status_q;
  logic [CNT_W-1:0]              snap_q, rd_val;
  logic                          snap_take;

  mbt_addr_decode #(.CH(NUM_CH), .IW(IDX_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr),
    .cnt_we(cnt_we), .match_we(match_we), .ctrl_we(ctrl_we),
    .ien_we(ien_we), .stat_we(stat_we), .rsel(rsel), .ridx(ridx)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int unsigned LEAD = leader_of(i);
    mbt_channel #(
      .CNT_W(CNT_W), .NUM_SRC(NUM_SRC),
      .WIDE(i >= WIDE_FROM), .LEADER(LEAD == i)
    ) u_ch (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(ctrl_we[i]), .match_we(match_we[i]), .cnt_we(cnt_we[i]),
      .wdata(bus_wdata), .tick_in(tick_in),
      .lead_cnt(cnt_q[LEAD]), .lead_tick(own_tick[LEAD]),
      .ctrl_q(ctrl_q[i]), .cnt_q(cnt_q[i]), .match_q(match_q[i]),
      .own_tick(own_tick[i]), .fire(fire_v[i])
    );
    assign rearm_v[i] = ctrl_q[i][CB_REARM];
  end

  mbt_status #(.CH(NUM_CH)) u_stat (
    .clk(clk), .rst_n(rst_n), .ien_we(ien_we), .stat_we(stat_we),
    .wbits(bus_wdata[STAT_LSB +: NUM_CH]), .fire(fire_v),
    .ien_q(ien_q), .status_q(status_q), .irq(irq)
  );

  // channels 9 and 11 (local 5 and 7) sample their lower neighbour
  assign snap_take = bus_rd && (rsel == RSEL_CNT) &&
                     (ridx == IDX_W'(5) || ridx == IDX_W'(7)) &&
                     ctrl_q[ridx][CB_SNAP];

  always_comb begin
    rd_val = '0;
    case (rsel)
      RSEL_CNT:    rd_val = cnt_q[ridx];
      RSEL_MATCH:  rd_val = match_q[ridx];
      RSEL_CTRL:   rd_val = CNT_W'(ctrl_q[ridx]);
      RSEL_STATUS: rd_val[STAT_LSB +: NUM_CH] = status_q;
      RSEL_IEN:    rd_val[STAT_LSB +: NUM_CH] = ien_q;
      RSEL_SNAP:   rd_val = snap_q;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      snap_q     <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_val;
      if (snap_take) snap_q <= cnt_q[ridx - 1'b1];
    end
  end
endmodule

// File: rtl/mbt_checker.sv
module mbt_checker #(
  parameter int unsigned CH      = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_SRC = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_rd,
  input logic                   bus_rvalid,
  input logic [CNT_W-1:0]       bus_wdata,
  input logic [NUM_SRC-1:0]     tick_in,
  input logic                   irq,
  input logic [CH-1:0]          fire_v,
  input logic [CH-1:0]          ien_q,
  input logic [CH-1:0]          status_q,
  input logic [CH-1:0]          cnt_we,
  input logic [CH-1:0]          ctrl_we,
  input logic [CH-1:0]          match_we,
  input logic [CH-1:0]          rearm_v,
  input logic [CH-1:0][CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0]       snap_q
);
  p_rvalid_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  p_rvalid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  p_snap_only_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(snap_q));
  p_irq_after_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((fire_v & ien_q) != '0) |=> irq);

  for (genvar i = 0; i < CH; i++) begin : g_chk
    p_fire_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire_v[i] |-> (tick_in != '0));
    p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we[i] |=> (cnt_q[i] == $past(bus_wdata)));
    p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_v[i] && !rearm_v[i] && !ctrl_we[i] && !match_we[i]) |=> !fire_v[i]);
    p_status_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_v[i] && ien_q[i]) |=> status_q[i]);
  end
endmodule

bind match_bank_timer mbt_checker #(
  .CH(mbt_pkg::NUM_CH), .CNT_W(CNT_W), .NUM_SRC(NUM_SRC)
) u_mbt_checker (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .bus_wdata(bus_wdata), .tick_in(tick_in), .irq(irq),
  .fire_v(fire_v), .ien_q(ien_q), .status_q(status_q),
  .cnt_we(cnt_we), .ctrl_we(ctrl_we), .match_we(match_we),
  .rearm_v(rearm_v), .cnt_q(cnt_q), .snap_q(snap_q)
);

// File: tb/tb_match_bank_timer.sv
`timescale 1ns/1ps
module tb_match_bank_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [4:0]  tick_in = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  match_bank_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tick_in(tick_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; tick_in = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk); tick_in = m;
    @(negedge clk); tick_in = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irq after reset", 32'(irq), 0);
    rd(8'h40, rv); chk("R1 counter 4", rv, 0);
    chk("R11 rvalid after read", 32'(bus_rvalid), 1);
    @(negedge clk); chk("R11 rvalid idle", 32'(bus_rvalid), 0);
    rd(8'h9C, rv); chk("R1 match 11", rv, 0);
    rd(8'hDC, rv); chk("R1 control 11", rv, 0);
    rd(8'h14, rv); chk("R1 status", rv, 0);
    rd(8'h1C, rv); chk("R1 enable", rv, 0);
    rd(8'h20, rv); chk("R1 snapshot", rv, 0);
  endtask

  task automatic t_clksel();
    do_reset();
    for (int code = 1; code <= 5; code++) begin
      wr(8'hC0, 32'(code));
      wr(8'h40, 0);
      pulse(5'(1 << (code - 1)));
      pulse(5'(1 << (code - 1)));
      pulse(~5'(1 << (code - 1)));
      rd(8'h40, rv); chk($sformatf("R2 select code %0d", code), rv, 2);
    end
    for (int code = 0; code < 8; code++) begin
      if (code >= 1 && code <= 5) continue;
      wr(8'hC0, 32'(code));
      wr(8'h40, 9);
      pulse(5'h1F);
      rd(8'h40, rv); chk($sformatf("R2 stopped code %0d", code), rv, 9);
    end
  endtask

  task automatic t_load();
    do_reset();
    wr(8'hC0, 1);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 100; tick_in = 5'h01;
    @(negedge clk); bus_wr = 1'b0; tick_in = '0;
    rd(8'h40, rv); chk("R3 load beats tick", rv, 100);
    pulse(5'h01);
    rd(8'h40, rv); chk("R3 count after load", rv, 101);
  endtask

  task automatic t_match();
    do_reset();
    wr(8'h1C, 32'h10);
    wr(8'hC0, 32'h49);
    wr(8'h80, 2);
    pulse(5'h01); pulse(5'h01);
    chk("R4 no event before match", 32'(irq), 0);
    rd(8'h40, rv); chk("R4 count at match", rv, 2);
    pulse(5'h01);
    chk("R10 irq on event", 32'(irq), 1);
    rd(8'h14, rv); chk("R9 status bit 4", rv, 32'h10);
    rd(8'h40, rv); chk("R4 zero on match", rv, 0);
    wr(8'h14, 32'h10);
    chk("R9 clear status drops irq", 32'(irq), 0);
    pulse(5'h01); pulse(5'h01);
    chk("R5 periodic not early", 32'(irq), 0);
    pulse(5'h01);
    chk("R5 periodic refire", 32'(irq), 1);
    wr(8'h14, 32'h10);
    wr(8'hC0, 32'h41);
    wr(8'h40, 0);
    pulse(5'h01); pulse(5'h01); pulse(5'h01);
    chk("R4 bit3 clear event", 32'(irq), 1);
    rd(8'h40, rv); chk("R4 bit3 clear keeps counting", rv, 3);
  endtask

  task automatic t_oneshot();
    do_reset();
    wr(8'h1C, 32'h10);
    wr(8'hC0, 32'h09);
    wr(8'h80, 1);
    pulse(5'h01); pulse(5'h01);
    chk("R5 one-shot first event", 32'(irq), 1);
    wr(8'h14, 32'h10);
    pulse(5'h01); pulse(5'h01);
    chk("R5 one-shot disarmed irq", 32'(irq), 0);
    rd(8'h14, rv); chk("R5 one-shot disarmed status", rv, 0);
    wr(8'h80, 1);
    pulse(5'h01); pulse(5'h01);
    chk("R5 rearm by match write", 32'(irq), 1);
  endtask

  task automatic t_gate();
    do_reset();
    wr(8'hC0, 32'h41);
    pulse(5'h01);
    rd(8'h14, rv); chk("R9 disabled event no status", rv, 0);
    chk("R10 disabled event no irq", 32'(irq), 0);
    wr(8'h1C, 32'h10);
    wr(8'h40, 0);
    pulse(5'h01);
    rd(8'h14, rv); chk("R9 enabled event", rv, 32'h10);
    wr(8'h40, 0);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h10; tick_in = 5'h01;
    @(negedge clk); bus_wr = 1'b0; tick_in = '0;
    rd(8'h14, rv); chk("R9 set beats clear", rv, 32'h10);
    wr(8'h14, 32'hFFF);
    rd(8'h14, rv); chk("R9 clear", rv, 0);
  endtask

  task automatic t_group();
    do_reset();
    wr(8'h1C, 32'h20);
    wr(8'hC0, 32'h01);
    wr(8'h80, 100);
    wr(8'h40, 5);
    wr(8'hC4, 32'h40);
    wr(8'h84, 5);
    wr(8'h44, 7);
    pulse(5'h01);
    rd(8'h14, rv); chk("R6 follower fires on leader count", rv, 32'h20);
    rd(8'h44, rv); chk("R6 follower counter holds", rv, 7);
    rd(8'h40, rv); chk("R6 leader counts", rv, 6);
    wr(8'hD0, 32'h01);
    pulse(5'h01);
    rd(8'h50, rv); chk("R6 leader ignores bit7", rv, 1);
    wr(8'hC4, 32'h81);
    pulse(5'h01);
    rd(8'h44, rv); chk("R6 own counter with bit7", rv, 8);
  endtask

  task automatic t_width();
    do_reset();
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'hC0, rv); chk("R7 narrow control", rv, 32'hFF);
    wr(8'hD0, 32'hFFFF_FFFF);
    rd(8'hD0, rv); chk("R7 wide control", rv, 32'h3FF);
    wr(8'hD0, 32'h101);
    wr(8'h50, 0);
    pulse(5'h01);
    rd(8'h50, rv); chk("R7 bit8 stops", rv, 0);
    wr(8'hD0, 32'h001);
    pulse(5'h01);
    rd(8'h50, rv); chk("R7 bit8 clear runs", rv, 1);
  endtask

  task automatic t_snap();
    do_reset();
    wr(8'h50, 32'h1234);
    wr(8'hD4, 32'h200);
    rd(8'h54, rv);
    rd(8'h20, rv); chk("R8 snapshot of channel 8", rv, 32'h1234);
    wr(8'h50, 32'h5555);
    wr(8'hD4, 0);
    rd(8'h54, rv);
    rd(8'h20, rv); chk("R8 no capture without bit9", rv, 32'h1234);
    wr(8'h58, 32'hBEEF);
    wr(8'hDC, 32'h200);
    rd(8'h5C, rv);
    rd(8'h20, rv); chk("R8 snapshot of channel 10", rv, 32'hBEEF);
    wr(8'hD8, 32'h200);
    wr(8'h58, 32'h77);
    rd(8'h58, rv);
    rd(8'h20, rv); chk("R8 even channel read no capture", rv, 32'hBEEF);
  endtask

  task automatic t_map();
    do_reset();
    wr(8'h3C, 32'hFFFF);
    rd(8'h3C, rv); chk("R11 unmapped read", rv, 0);
    wr(8'h41, 32'hAB);
    rd(8'h40, rv); chk("R11 misaligned write ignored", rv, 0);
    wr(8'h88, 32'hCAFE);
    rd(8'h88, rv); chk("R11 match 6 offset", rv, 32'hCAFE);
    rd(8'h8A, rv); chk("R11 misaligned read", rv, 0);
  endtask

  initial begin
    t_reset();
    t_clksel();
    t_load();
    t_match();
    t_oneshot();
    t_gate();
    t_group();
    t_width();
    t_snap();
    t_map();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule